// File: doc/BRIEF.md
# BCD centisecond stopwatch counter

This block keeps elapsed time in hundredths of a second as a chain of packed-BCD bytes: a centisecond byte, a seconds byte, a minutes byte and three hours bytes that together give six decimal digits of hours. The largest value is 999,999 h 59 min 59.99 s (359,999,999,999 centiseconds). A one-cycle strobe at 100 Hz on `tick` advances the count when the block is enabled and not stopped.

Software reaches every register through a small synchronous byte port: a write is applied at the clock edge where `wr_en` is high, and a read returns the byte at `addr` one clock edge later on `rdata`. Besides the six time bytes there is a stop-control byte, a function byte that must select both stopwatch operation and centisecond resolution before counting starts, a flags byte, one spare storage byte and a 64-byte scratch memory. To load a new time, software sets the stop bit, writes the six time bytes and clears the stop bit.

Top module: `bcd_stopwatch`

## Requirements
- R1: The time bytes are at addresses 0x00 (centiseconds), 0x01 (seconds), 0x02 (minutes), 0x03 (hours digits 1-0), 0x04 (hours digits 3-2) and 0x05 (hours digits 5-4); a byte written at an address reads back on `rdata` one clock edge after `addr` is presented.
- R2: On each counting tick the centisecond byte steps through BCD 0x00..0x99, seconds and minutes through 0x00..0x59, each hours byte through 0x00..0x99; a byte advances only when every lower byte is at its terminal value (0x99 or 0x59) on that tick, and a byte at its terminal value then returns to 0x00.
- R3: At 99,99,99,59,59,99 (hours high to centiseconds) the next counting tick clears all six bytes to 0x00 and sets bit 0 of the flags byte.
- R4: Bit 7 of the seconds and minutes bytes is a flag held apart from the 7-bit BCD value: counting never changes it, a write sets it.
- R5: The stop byte at 0x2E holds the stop bit in bit 0 (other bits read 0); it resets to 1, and while it is 1 ticks do not change the count.
- R6: The function byte at 0x28 resets to 0x00; ticks advance the count only while both bit 4 and bit 7 are 1.
- R7: A write to any time byte takes effect at that edge, and a tick in the same cycle changes no time byte.
- R8: The flags byte at 0x2B resets to 0x00; a write clears every flag bit whose written bit is 0 and keeps the others, so writing 0x00 clears all flags.
- R9: A spare byte at 0x2C and a 64-byte memory at 0x40..0x7F can be written and read back through the same port.
- R10: After reset all time bytes read 0x00; addresses with no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 100 Hz advance strobe |
| wr_en | input | 1 | Write strobe for the byte port |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the address presented one edge earlier |

## Verification
On every cycle the assertions check that a byte at its terminal value rolls to zero when it advances, that counting leaves the seconds and minutes flag bits untouched, that the count holds while stopped or not enabled, that a time write wins over a same-cycle tick and that a full wrap raises the flag. Only the bench scenarios show the carry cascading across all six bytes from chosen starting values, the exact BCD sequences read back through the port, the write-zero-to-clear flag behaviour and the storage bytes holding data.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NFIELDS   = 6;
  localparam int RAM_AW    = 6;
  localparam logic [ADDR_W-1:0] A_FUNC  = 8'h28;
  localparam logic [ADDR_W-1:0] A_FLAGS = 8'h2B;
  localparam logic [ADDR_W-1:0] A_SPARE = 8'h2C;
  localparam logic [ADDR_W-1:0] A_STOP  = 8'h2E;
  localparam logic [ADDR_W-1:0] A_RAM   = 8'h40;
  localparam int FN_MODE_BIT = 4;
  localparam int FN_RES_BIT  = 7;

  function automatic logic [3:0] tens_limit(input int idx);
    return (idx == 1 || idx == 2) ? 4'd5 : 4'd9;
  endfunction

  function automatic bit has_flag(input int idx);
    return (idx == 1 || idx == 2);
  endfunction
endpackage

// File: rtl/sw_bcd_field.sv
module sw_bcd_field
  import sw_pkg::*;
#(
  parameter logic [3:0] TENS_MAX = 4'd9,
  parameter bit         HAS_FLAG = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_val,
  output logic [BYTE_W-1:0] q,
  output logic              at_term
);
  localparam logic [BYTE_W-1:0] TERM = {TENS_MAX, 4'h9};

  logic [BYTE_W-1:0] val, nxt_val;

  always_comb begin
    val = HAS_FLAG ? {1'b0, q[BYTE_W-2:0]} : q;
    at_term = (val == TERM);
    if (at_term)
      nxt_val = '0;
    else if (val[3:0] == 4'h9)
      nxt_val = {val[7:4] + 4'h1, 4'h0};
    else
      nxt_val = val + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ld)
      q <= ld_val;
    else if (inc)
      q <= HAS_FLAG ? {q[BYTE_W-1], nxt_val[BYTE_W-2:0]} : nxt_val;
  end

  // R2: a terminal byte that advances returns to zero
  p_roll_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && at_term && !ld) |=> (q[BYTE_W-2:0] == '0));

  // R4: counting keeps the flag bit
  generate
    if (HAS_FLAG) begin : g_flag_chk
      p_flag_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> (q[BYTE_W-1] == $past(q[BYTE_W-1])));
    end
  endgenerate

  // R5/R6: without advance or load the byte holds
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/sw_ram.sv
module sw_ram
  import sw_pkg::*;
#(
  parameter int AW = RAM_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
    q <= mem[a];
  end
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
  import sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int RAM_SEL_W = ADDR_W - RAM_AW;

  logic [BYTE_W-1:0] tq [NFIELDS];
  logic [NFIELDS-1:0] at_term, ld;
  logic [NFIELDS:0]   carry;
  logic               time_wr, run_en, adv, wrap;
  logic               stop_q;
  logic [BYTE_W-1:0]  func_q, flags_q, spare_q;
  logic [BYTE_W-1:0]  reg_rd_q, ram_q, reg_rd_d;
  logic               ram_hit, ram_sel_q;

  assign time_wr = wr_en && (addr < ADDR_W'(NFIELDS));
  assign run_en  = func_q[FN_MODE_BIT] && func_q[FN_RES_BIT] && !stop_q;
  assign adv     = tick && run_en && !time_wr;
  assign carry[0] = adv;
  assign wrap    = carry[NFIELDS];

  genvar i;
  generate
    for (i = 0; i < NFIELDS; i++) begin : g_field
      assign ld[i] = wr_en && (addr == ADDR_W'(i));
      assign carry[i+1] = carry[i] && at_term[i];
      sw_bcd_field #(
        .TENS_MAX(tens_limit(i)),
        .HAS_FLAG(has_flag(i))
      ) u_fld (
        .clk    (clk),
        .rst    (rst),
        .inc    (carry[i]),
        .ld     (ld[i]),
        .ld_val (wdata),
        .q      (tq[i]),
        .at_term(at_term[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q  <= 1'b1;
      func_q  <= '0;
      flags_q <= '0;
      spare_q <= '0;
    end else begin
      if (wr_en && addr == A_STOP)  stop_q  <= wdata[0];
      if (wr_en && addr == A_FUNC)  func_q  <= wdata;
      if (wr_en && addr == A_SPARE) spare_q <= wdata;
      flags_q <= ((wr_en && addr == A_FLAGS) ? (flags_q & wdata) : flags_q)
                 | {{(BYTE_W-1){1'b0}}, wrap};
    end
  end

  assign ram_hit = (addr[ADDR_W-1 -: RAM_SEL_W] == A_RAM[ADDR_W-1 -: RAM_SEL_W]);

  sw_ram u_ram (
    .clk(clk),
    .we (wr_en && ram_hit),
    .a  (addr[RAM_AW-1:0]),
    .d  (wdata),
    .q  (ram_q)
  );

  always_comb begin
    reg_rd_d = '0;
    if (addr < ADDR_W'(NFIELDS)) reg_rd_d = tq[addr[2:0]];
    else if (addr == A_STOP)     reg_rd_d = {{(BYTE_W-1){1'b0}}, stop_q};
    else if (addr == A_FUNC)     reg_rd_d = func_q;
    else if (addr == A_FLAGS)    reg_rd_d = flags_q;
    else if (addr == A_SPARE)    reg_rd_d = spare_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      ram_sel_q <= 1'b0;
    end else begin
      reg_rd_q  <= reg_rd_d;
      ram_sel_q <= ram_hit;
    end
  end

  assign rdata = ram_sel_q ? ram_q : reg_rd_q;

  // R5: stopped count does not move
  p_stop_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !time_wr) |=> (tq[0] == $past(tq[0])));

  // R6: both function bits needed to count
  p_func_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!(func_q[FN_MODE_BIT] && func_q[FN_RES_BIT]) && !time_wr) |=> $stable(tq[0]));

  // R7: write wins over same-cycle tick
  p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=> (tq[0] == $past(wdata)));

  // R3: full wrap clears and flags
  p_wrap_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && (&at_term)) |=> (flags_q[0] && tq[NFIELDS-1] == '0 && tq[0] == '0));
endmodule

// File: tb/sim_bcd_stopwatch.sv
`timescale 1ns/1ps
module sim_bcd_stopwatch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] a;
    string      req;
  } item_t;
  item_t sb[$];
  logic rd_req = 1'b0, rd_pend = 1'b0;

  always #4 clk = ~clk;

  bcd_stopwatch u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) rd_pend <= rd_req;

  // monitor
  always @(negedge clk) begin
    if (rd_pend && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.req, it.a, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    it.exp = e; it.a = a; it.req = req;
    sb.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [7:0] v0, v1, v2, v3, v4, v5);
    wr(8'h2E, 8'h01, 0);
    wr(8'h00, v0, 0); wr(8'h01, v1, 0); wr(8'h02, v2, 0);
    wr(8'h03, v3, 0); wr(8'h04, v4, 0); wr(8'h05, v5, 0);
    wr(8'h2E, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 / R5 / R6 / R8 reset state
    for (int a = 0; a < 6; a++) rd(8'(a), 8'h00, "R10");
    rd(8'h2E, 8'h01, "R5");
    rd(8'h28, 8'h00, "R6");
    rd(8'h2B, 8'h00, "R8");
    rd(8'h10, 8'h00, "R10");

    // R5: enabled but stopped
    wr(8'h28, 8'h90, 0);
    pulse(2);
    rd(8'h00, 8'h00, "R5");
    // R6: only mode bit
    wr(8'h2E, 8'h00, 0);
    wr(8'h28, 8'h10, 0);
    pulse(2);
    rd(8'h00, 8'h00, "R6");
    wr(8'h28, 8'h80, 0);
    pulse(1);
    rd(8'h00, 8'h00, "R6");
    // R2: basic counting
    wr(8'h28, 8'h90, 0);
    pulse(3);
    rd(8'h00, 8'h03, "R2");
    pulse(9);
    rd(8'h00, 8'h12, "R2");

    // R1/R2/R4 cascade with flag in seconds
    load(8'h98, 8'hD9, 8'h59, 8'h99, 8'h99, 8'h07);
    rd(8'h01, 8'hD9, "R1");
    rd(8'h05, 8'h07, "R1");
    pulse(1);
    rd(8'h00, 8'h99, "R2");
    pulse(1);
    rd(8'h00, 8'h00, "R2");
    rd(8'h01, 8'h80, "R4");
    rd(8'h02, 8'h00, "R2");
    rd(8'h03, 8'h00, "R2");
    rd(8'h04, 8'h00, "R2");
    rd(8'h05, 8'h08, "R2");
    // R2: minutes advance without hours
    load(8'h99, 8'h59, 8'h85, 8'h41, 8'h00, 8'h00);
    pulse(1);
    rd(8'h02, 8'h86, "R4");
    rd(8'h03, 8'h41, "R2");

    // R3: full wrap
    load(8'h99, 8'h59, 8'h59, 8'h99, 8'h99, 8'h99);
    pulse(1);
    for (int a = 0; a < 6; a++) rd(8'(a), 8'h00, "R3");
    rd(8'h2B, 8'h01, "R3");
    // R8: write 1 keeps, write 0 clears
    wr(8'h2B, 8'hFF, 0);
    rd(8'h2B, 8'h01, "R8");
    wr(8'h2B, 8'h00, 0);
    rd(8'h2B, 8'h00, "R8");

    // R7: write with same-cycle tick
    load(8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    wr(8'h00, 8'h42, 1);
    rd(8'h00, 8'h42, "R7");
    rd(8'h01, 8'h00, "R7");

    // R9: storage
    wr(8'h2C, 8'hA5, 0);
    wr(8'h40, 8'h11, 0);
    wr(8'h7F, 8'hEE, 0);
    wr(8'h55, 8'h3C, 0);
    rd(8'h2C, 8'hA5, "R9");
    rd(8'h40, 8'h11, "R9");
    rd(8'h7F, 8'hEE, "R9");
    rd(8'h55, 8'h3C, "R9");
    rd(8'h00, 8'h42, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule